// File: doc/BRIEF.md
# FSK Tag Waveform Synthesizer

This block produces the one-bit modulation stream that a simulated low-frequency frequency-shift-keyed tag presents to a reader. It emits one sample for each field-clock tick. Each data bit taken from the input stream picks one of two sub-carrier divisors. The block then outputs square waves of that period until one bit period, `bit_len` ticks long, is filled.

When `bit_len` is not a whole multiple of the chosen divisor, the leftover ticks are handled in one of two ways. If the divisor is an exact multiple of the leftover, a full extra wave is added on every k-th such bit, where k = divisor / leftover. Otherwise every bit ends with a shortened wave whose length equals the leftover. A free-running 16-bit counter of bits that have a leftover sets the rhythm of the extra waves. The next bit is taken from the stream only after the last sample of the current bit has been output.

Top module: `fsk_wave_gen`

## Requirements
- R1: After reset `mod_out` is 0, `bit_done` is 0 and `bit_ready` is 1.
- R2: A data bit of 1 selects `div_hi` and a data bit of 0 selects `div_lo`. With `invert` at 1 this mapping is swapped. Divisor and bit length are captured when the bit is accepted.
- R3: A wave of length L outputs L - L/2 zeros first and then L/2 ones, using integer halving, so an odd L gives the extra sample to the zero part.
- R4: Each bit contains `bit_len / fc` full waves of period fc, using integer division.
- R5: A 16-bit modifier count is cleared by reset and incremented, with natural wrap, for every accepted bit whose remainder r = `bit_len % fc` is nonzero.
- R6: If r is nonzero and fc % r is 0, one more full wave of period fc is appended to the bit whenever the incremented modifier count is a multiple of fc / r.
- R7: If r is nonzero and fc % r is not 0, every bit ends with one partial wave of length r shaped as in R3.
- R8: `mod_out` advances by exactly one sample on each clock edge where `tick` is 1 while a bit is in progress, and it holds its value on every edge where `tick` is 0.
- R9: `bit_done` pulses for one cycle together with the last sample of a bit. `bit_ready` is 0 from acceptance until that sample, and a bit is accepted on an edge where both `bit_valid` and `bit_ready` are 1.
- R10: With divisors 8 and 10 and bit lengths 48 and 50, a bit is six waves of 00001111 or five waves of 0000011111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_hi | input | DIV_W | Sub-carrier period for a (non-inverted) one |
| div_lo | input | DIV_W | Sub-carrier period for a (non-inverted) zero |
| bit_len | input | LEN_W | Bit period in field-clock ticks, at least the chosen divisor |
| invert | input | 1 | Swaps the divisor mapping |
| bit_valid | input | 1 | Stream bit offered |
| bit_data | input | 1 | Stream bit value |
| bit_ready | output | 1 | Block can accept a bit |
| tick | input | 1 | Field-clock tick enable |
| mod_out | output | 1 | Modulation sample |
| bit_done | output | 1 | Last sample of a bit output this cycle |

## Verification
The block is driven with several kinds of bit period. Whole-multiple periods, including the 8/10 pair, isolate the wave shape and the divisor choice. Periods whose remainder divides the divisor expose the extra-wave rhythm, and a reset in the middle of such a sequence shows that the modifier count restarts. Periods with a non-dividing remainder and odd divisors separate the partial-wave path and the odd-length split from the full-wave path. Random divisors, lengths, data, invert and tick gaps mix all of these and show that missing ticks stall the stream without dropping or repeating a sample.

// File: rtl/fsk_wave_gen.sv
module fsk_wave_gen #(
  parameter int DIV_W  = 8,
  parameter int LEN_W  = 8,
  parameter int MCNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_hi,
  input  logic [DIV_W-1:0] div_lo,
  input  logic [LEN_W-1:0] bit_len,
  input  logic             invert,
  input  logic             bit_valid,
  input  logic             bit_data,
  output logic             bit_ready,
  input  logic             tick,
  output logic             mod_out,
  output logic             bit_done
);

  localparam int W = (DIV_W > LEN_W) ? DIV_W : LEN_W;

  logic             busy, in_part;
  logic [DIV_W-1:0] fc_r, part_r, pos;
  logic [W:0]       waves_left;
  logic [MCNT_W-1:0] mcnt;

  assign bit_ready = !busy;
  wire take = bit_valid && !busy;

  wire [DIV_W-1:0] fc_sel = (bit_data ^ invert) ? div_hi : div_lo;
  wire [W-1:0] len_x  = W'(bit_len);
  wire [W-1:0] fc_x   = W'(fc_sel);
  wire [W-1:0] q      = len_x / fc_x;
  wire [W-1:0] r      = len_x % fc_x;
  wire         has_rem = r != '0;
  wire [W-1:0] r_safe = has_rem ? r : W'(1);
  wire         whole_fit = has_rem && ((fc_x % r_safe) == '0);
  wire [W-1:0] step   = fc_x / r_safe;
  wire [MCNT_W-1:0] mcnt_nx = mcnt + MCNT_W'(has_rem);
  wire         extra  = whole_fit && ((mcnt_nx % MCNT_W'(step)) == '0);
  wire [W:0]   n_waves = {1'b0, q} + (W+1)'(extra);
  wire [DIV_W-1:0] tail = (has_rem && !whole_fit) ? DIV_W'(r) : '0;

  wire [DIV_W-1:0] cur_len = in_part ? part_r : fc_r;
  wire [DIV_W-1:0] zeros   = cur_len - (cur_len >> 1);
  wire             smp     = pos >= zeros;
  wire             last_pos = pos == cur_len - DIV_W'(1);
  wire             last_smp = last_pos &&
                              (in_part || (waves_left == (W+1)'(1) && part_r == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      in_part    <= 1'b0;
      fc_r       <= '0;
      part_r     <= '0;
      pos        <= '0;
      waves_left <= '0;
      mcnt       <= '0;
      mod_out    <= 1'b0;
      bit_done   <= 1'b0;
    end else begin
      bit_done <= 1'b0;
      if (take) begin
        busy       <= 1'b1;
        fc_r       <= fc_sel;
        part_r     <= tail;
        pos        <= '0;
        waves_left <= n_waves;
        in_part    <= n_waves == '0;
        mcnt       <= mcnt_nx;
      end else if (busy && tick) begin
        mod_out <= smp;
        if (last_smp) begin
          busy     <= 1'b0;
          bit_done <= 1'b1;
          pos      <= '0;
        end else if (last_pos) begin
          pos <= '0;
          if (waves_left == (W+1)'(1)) in_part <= 1'b1;
          else waves_left <= waves_left - (W+1)'(1);
        end else begin
          pos <= pos + DIV_W'(1);
        end
      end
    end
  end

  p_done_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |-> $past(tick));
  p_ready_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |-> bit_ready);
  p_take_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_ready) |=> !bit_ready);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready |=> !bit_done);
  p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(mod_out));
  p_pos_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pos < cur_len);

endmodule

// File: tb/tb_fsk_wave_gen.sv
`timescale 1ns/1ps
module tb_fsk_wave_gen;
  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] div_hi, div_lo, bit_len;
  logic invert, bit_valid, bit_data, tick;
  logic bit_ready, mod_out, bit_done;

  int checks = 0, fails = 0;
  logic [15:0] mcnt_m;
  logic exp_s [0:1023];
  int exp_n;

  always #10 clk = ~clk;

  fsk_wave_gen dut (
    .clk(clk), .rst_n(rst_n), .div_hi(div_hi), .div_lo(div_lo),
    .bit_len(bit_len), .invert(invert), .bit_valid(bit_valid),
    .bit_data(bit_data), .bit_ready(bit_ready), .tick(tick),
    .mod_out(mod_out), .bit_done(bit_done));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic add_wave(input int len);
    for (int p = 0; p < len; p++) begin
      exp_s[exp_n] = (p >= len - len / 2);
      exp_n++;
    end
  endtask

  // Expected bit per R2..R7
  task automatic build_exp(input bit d, input bit inv, input int hi, input int lo, input int len);
    int fc, w, r;
    bit extra;
    fc = (d ^ inv) ? hi : lo;
    w = len / fc;
    r = len % fc;
    exp_n = 0;
    extra = 1'b0;
    if (r != 0) begin
      mcnt_m = mcnt_m + 16'd1;
      if (fc % r == 0 && (int'(mcnt_m) % (fc / r)) == 0) extra = 1'b1;
    end
    for (int k = 0; k < w; k++) add_wave(fc);
    if (extra) add_wave(fc);
    if (r != 0 && fc % r != 0) add_wave(r);
  endtask

  task automatic run_bit(input bit d, input bit inv, input int hi, input int lo,
                         input int len, input int tick_pct, input string req);
    int i;
    logic prev;
    @(negedge clk);
    div_hi = 8'(hi); div_lo = 8'(lo); bit_len = 8'(len);
    invert = inv; bit_data = d; bit_valid = 1'b1;
    tick = ($urandom % 100) < 50;
    chk(bit_ready === 1'b1, "R9 ready before accept", int'(bit_ready), 1);
    build_exp(d, inv, hi, lo, len);
    @(negedge clk);
    bit_valid = 1'b0;
    bit_data = $urandom;
    chk(bit_ready === 1'b0, "R9 busy after accept", int'(bit_ready), 0);
    i = 0;
    while (i < exp_n) begin
      prev = mod_out;
      tick = ($urandom % 100) < tick_pct;
      @(negedge clk);
      if (tick) begin
        chk(mod_out === exp_s[i], req, int'(mod_out), int'(exp_s[i]));
        chk(bit_done === (i == exp_n - 1), "R9 done strobe", int'(bit_done), int'(i == exp_n - 1));
        i++;
      end else begin
        chk(mod_out === prev && bit_done === 1'b0, "R8 hold without tick", int'(mod_out), int'(prev));
      end
    end
    chk(bit_ready === 1'b1, "R9 ready after last sample", int'(bit_ready), 1);
    tick = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; bit_valid = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mcnt_m = 16'd0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9: watchdog expired, actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    div_hi = 8'd10; div_lo = 8'd8; bit_len = 8'd48; invert = 1'b0; bit_data = 1'b0;
    do_reset();
    @(negedge clk);
    chk(mod_out === 1'b0 && bit_done === 1'b0, "R1 reset outputs", int'(mod_out), 0);
    chk(bit_ready === 1'b1, "R1 reset ready", int'(bit_ready), 1);

    // R10 / R3 / R4: whole multiples, 8 and 10
    run_bit(1'b0, 1'b0, 10, 8, 48, 100, "R10 fc8 x6");
    run_bit(1'b1, 1'b0, 10, 8, 50, 100, "R10 fc10 x5");
    // R2: invert swaps mapping
    run_bit(1'b1, 1'b1, 10, 8, 48, 100, "R2 invert one->lo");
    run_bit(1'b0, 1'b1, 10, 8, 50, 100, "R2 invert zero->hi");
    // R6 / R5: remainder 2 divides 8, extra wave every 4th bit
    for (int k = 0; k < 9; k++) run_bit(1'b0, 1'b0, 10, 8, 50, 80, "R6 extra wave");
    do_reset();
    for (int k = 0; k < 5; k++) run_bit(1'b0, 1'b0, 10, 8, 50, 80, "R5 count restarts");
    // R7: remainder 5 with fc 8, and odd divisors (R3)
    for (int k = 0; k < 3; k++) run_bit(1'b0, 1'b0, 7, 8, 53, 90, "R7 partial wave");
    run_bit(1'b1, 1'b0, 7, 8, 45, 90, "R3 odd fc7 R7 tail3");
    run_bit(1'b1, 1'b0, 5, 8, 15, 60, "R3 odd fc5");
    // R8: sparse ticks
    run_bit(1'b1, 1'b0, 6, 8, 20, 20, "R8 sparse ticks");

    for (int n = 0; n < 300; n++) begin
      int hi, lo, mx, len;
      hi = 2 + ($urandom % 23);
      lo = 2 + ($urandom % 23);
      mx = (hi > lo) ? hi : lo;
      len = mx + ($urandom % 60);
      run_bit(1'($urandom), 1'($urandom), hi, lo, len, 50 + ($urandom % 51), "R4 random bit");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule